// File: doc/BRIEF.md
# Light-Load Conduction Mode Controller

This block chooses, one switching cycle at a time, whether a step-down converter runs in continuous conduction or in discontinuous conduction with diode-emulation skipping. Each cycle the current-sense front end delivers one signed code for the inductor valley current. The block keeps a run of low-valley cycles while it is in continuous mode. When the run is long enough it raises a mode flag for the gate-drive sequencer. A single clearly positive valley sample brings the flag down again.

The entry threshold follows the selected current-limit level. The exit threshold is fixed. Discontinuous operation is allowed only when the static configuration enable is set and switching is active. Either condition going low forces continuous mode and discards any partial run.

Samples arrive on a valid/ready stream. The block never applies back-pressure once it is out of reset: `smp_ready` is low during reset, goes high on the first clock edge after reset is released, and stays high. A sample counts as taken on a rising clock edge where both `smp_valid` and `smp_ready` are high. Cycles without a taken sample leave the run and the mode untouched.

Top module: `lightload_mode_ctrl`

## Requirements
- R1: While reset is asserted, `dcm_mode` is 0 (continuous) and `smp_ready` is 0. `smp_ready` becomes 1 on the first clock edge after reset is released.
- R2: In continuous mode, `dcm_mode` rises on the clock edge that takes the 48th consecutive sample lying strictly below the entry threshold.
- R3: Samples are two's-complement codes at 10 mA per LSB. The entry threshold is chosen by `lim_sel`: 0 (38 A limit) gives -173, 1 (33 A limit) gives -157, and 2 or 3 (28 A limit) give -126.
- R4: In continuous mode, a taken sample at or above the entry threshold restarts the run from zero. A sample equal to the threshold counts as not low.
- R5: In discontinuous mode, `dcm_mode` falls on the edge that takes a single sample strictly greater than +60 (0.6 A). A sample of exactly +60 does not cause exit.
- R6: When `dcm_en` is 0, `dcm_mode` is 0 after the next clock edge and the run is cleared. A later entry then needs a full 48 fresh low samples.
- R7: When `sw_en` is 0, `dcm_mode` is 0 after the next clock edge and the run is cleared, in the same way as R6.
- R8: Apart from reset and R6/R7, `dcm_mode` changes only on an edge that takes a sample.
- R9: In discontinuous mode, taken samples at or below +60 leave the mode unchanged. After an exit, re-entry needs a new run of 48 low samples.
- R10: Cycles without a taken sample neither extend nor break a run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_en | input | 1 | Switching active; low forces continuous mode |
| dcm_en | input | 1 | Static configuration enable for discontinuous operation |
| lim_sel | input | 2 | Current-limit level selector (see R3) |
| smp_valid | input | 1 | One valley sample is offered this cycle |
| smp_ready | output | 1 | Block accepts samples (high whenever out of reset) |
| smp_code | input | 12 | Signed valley current code, 10 mA per LSB |
| dcm_mode | output | 1 | 1 = discontinuous mode allowed, 0 = continuous |

## Verification
Runs of exactly 47 and exactly 48 low samples at each current-limit level separate an off-by-one in the run length from a wrong threshold choice. Samples equal to the threshold are compared with samples one code below it to expose `<` versus `<=`. Exit is probed with +60 and +61 to pin down the strictness of the fixed exit threshold. Runs broken by idle cycles, by a single at-threshold sample, and by short drops of either enable show whether the run is held, restarted or cleared in each case.

// File: rtl/lightload_pkg.sv
package lightload_pkg;
  typedef enum logic {
    MODE_CCM = 1'b0,
    MODE_DCM = 1'b1
  } cond_mode_e;

  // selector codes for the current-limit level
  localparam logic [1:0] LIM_HIGH = 2'd0;
  localparam logic [1:0] LIM_MID  = 2'd1;
endpackage

// File: rtl/lightload_thresh_sel.sv
module lightload_thresh_sel #(
  parameter int SW       = 12,
  parameter int THR_HIGH = -173,
  parameter int THR_MID  = -157,
  parameter int THR_LOW  = -126
) (
  input  logic [1:0]           lim_sel,
  output logic signed [SW-1:0] entry_thr
);
  import lightload_pkg::*;

  localparam logic signed [SW-1:0] T_HIGH = THR_HIGH[SW-1:0];
  localparam logic signed [SW-1:0] T_MID  = THR_MID[SW-1:0];
  localparam logic signed [SW-1:0] T_LOW  = THR_LOW[SW-1:0];

  always_comb begin
    unique case (lim_sel)
      LIM_HIGH: entry_thr = T_HIGH;
      LIM_MID:  entry_thr = T_MID;
      default:  entry_thr = T_LOW;
    endcase
  end
endmodule

// File: rtl/lightload_run_count.sv
module lightload_run_count #(
  parameter int RUN_LEN = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  input  logic below,
  output logic run_done
);
  localparam int CW = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last  = (cnt_q == LAST);
  assign run_done = step && below && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (step) begin
      if (!below || at_last) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/lightload_mode_fsm.sv
module lightload_mode_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic force_ccm,
  input  logic take,
  input  logic run_done,
  input  logic above_exit,
  output lightload_pkg::cond_mode_e mode
);
  import lightload_pkg::*;

  cond_mode_e mode_q;
  assign mode = mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_CCM;
    end else if (force_ccm) begin
      mode_q <= MODE_CCM;
    end else if (take) begin
      unique case (mode_q)
        MODE_CCM: if (run_done)   mode_q <= MODE_DCM;
        MODE_DCM: if (above_exit) mode_q <= MODE_CCM;
        default:  mode_q <= MODE_CCM;
      endcase
    end
  end
endmodule

// File: rtl/lightload_mode_ctrl.sv
module lightload_mode_ctrl #(
  parameter int SW        = 12,
  parameter int RUN_LEN   = 48,
  parameter int THR_HIGH  = -173,
  parameter int THR_MID   = -157,
  parameter int THR_LOW   = -126,
  parameter int EXIT_CODE = 60
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sw_en,
  input  logic                 dcm_en,
  input  logic [1:0]           lim_sel,
  input  logic                 smp_valid,
  output logic                 smp_ready,
  input  logic signed [SW-1:0] smp_code,
  output logic                 dcm_mode
);
  import lightload_pkg::*;

  localparam logic signed [SW-1:0] EXIT_THR = EXIT_CODE[SW-1:0];

  logic                 ready_q;
  logic                 take;
  logic                 force_ccm;
  logic signed [SW-1:0] entry_thr;
  logic                 below;
  logic                 above_exit;
  logic                 run_done;
  cond_mode_e           mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign smp_ready  = ready_q;
  assign take       = smp_valid && ready_q;
  assign force_ccm  = !sw_en || !dcm_en;
  assign below      = smp_code < entry_thr;
  assign above_exit = smp_code > EXIT_THR;

  lightload_thresh_sel #(
    .SW(SW), .THR_HIGH(THR_HIGH), .THR_MID(THR_MID), .THR_LOW(THR_LOW)
  ) u_thr (
    .lim_sel  (lim_sel),
    .entry_thr(entry_thr)
  );

  lightload_run_count #(.RUN_LEN(RUN_LEN)) u_run (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (force_ccm || (mode == MODE_DCM)),
    .step    (take && (mode == MODE_CCM)),
    .below   (below),
    .run_done(run_done)
  );

  lightload_mode_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .force_ccm (force_ccm),
    .take      (take),
    .run_done  (run_done),
    .above_exit(above_exit),
    .mode      (mode)
  );

  assign dcm_mode = (mode == MODE_DCM);
endmodule

// File: rtl/lightload_mode_ctrl_chk.sv
module lightload_mode_ctrl_chk #(
  parameter int SW        = 12,
  parameter int THR_LOW   = -126,
  parameter int EXIT_CODE = 60
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sw_en,
  input logic                 dcm_en,
  input logic                 smp_valid,
  input logic                 smp_ready,
  input logic signed [SW-1:0] smp_code,
  input logic                 dcm_mode
);
  logic take;
  assign take = smp_valid && smp_ready;

  a_r5_exit_single: assert property (@(posedge clk) disable iff (!rst_n)
    (dcm_mode && take && (int'(smp_code) > EXIT_CODE)) |=> !dcm_mode);

  a_r6_cfg_off: assert property (@(posedge clk) disable iff (!rst_n)
    !dcm_en |=> !dcm_mode);

  a_r7_sw_off: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_en |=> !dcm_mode);

  a_r8_no_strobe_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && sw_en && dcm_en) |=> $stable(dcm_mode));

  a_r2_entry_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dcm_mode) |-> $past(take && (int'(smp_code) < THR_LOW)));

  a_r9_dcm_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dcm_mode && take && sw_en && dcm_en && (int'(smp_code) <= EXIT_CODE)) |=> dcm_mode);
endmodule

bind lightload_mode_ctrl lightload_mode_ctrl_chk #(
  .SW(SW), .THR_LOW(THR_LOW), .EXIT_CODE(EXIT_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_en(sw_en), .dcm_en(dcm_en),
  .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_code(smp_code),
  .dcm_mode(dcm_mode)
);

// File: tb/lightload_mode_ctrl_test.sv
`timescale 1ns/1ps
module lightload_mode_ctrl_test;
  localparam int SW = 12;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 sw_en = 1'b0;
  logic                 dcm_en = 1'b0;
  logic [1:0]           lim_sel = 2'd0;
  logic                 smp_valid = 1'b0;
  logic                 smp_ready;
  logic signed [SW-1:0] smp_code = '0;
  logic                 dcm_mode;

  int    total = 0;
  int    bad = 0;
  bit    armed = 1'b0;
  string tag = "R1";

  // reference model state
  bit m_dcm = 1'b0;
  bit m_rdy = 1'b0;
  int m_run = 0;

  always #5 clk = ~clk;

  lightload_mode_ctrl uut (
    .clk(clk), .rst_n(rst_n), .sw_en(sw_en), .dcm_en(dcm_en),
    .lim_sel(lim_sel), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_code(smp_code), .dcm_mode(dcm_mode)
  );

  function automatic int thr_of(input logic [1:0] s);
    if (s == 2'd0) return -173;
    if (s == 2'd1) return -157;
    return -126;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dcm = 0; m_rdy = 0; m_run = 0;
    end else begin
      if (!sw_en || !dcm_en) begin
        m_dcm = 0; m_run = 0;
      end else if (smp_valid && m_rdy) begin
        if (!m_dcm) begin
          if (int'(smp_code) < thr_of(lim_sel)) begin
            m_run++;
            if (m_run == 48) begin m_dcm = 1; m_run = 0; end
          end else m_run = 0;
        end else if (int'(smp_code) > 60) begin
          m_dcm = 0; m_run = 0;
        end
      end
      m_rdy = 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (armed) begin
      chk(tag, int'(dcm_mode), int'(m_dcm), "dcm_mode vs model");
      chk(tag, int'(smp_ready), int'(m_rdy), "smp_ready vs model");
    end
  end

  task automatic send(input bit v, input int code, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      smp_valid = v;
      smp_code  = code[SW-1:0];
    end
    @(negedge clk); #1;
    smp_valid = 1'b0;
  endtask

  task automatic expect_mode(input string req, input int exp);
    @(negedge clk);
    chk(req, int'(dcm_mode), exp, "directed dcm_mode");
  endtask

  task automatic leave_dcm();
    send(1, 61, 1);
  endtask

  initial begin
    #100000000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    armed = 1'b1;
    tag = "R1";
    @(negedge clk);
    chk("R1", int'(dcm_mode), 0, "mode in reset");
    chk("R1", int'(smp_ready), 0, "ready in reset");
    #1 rst_n = 1'b1; sw_en = 1'b1; dcm_en = 1'b1;
    @(negedge clk);
    chk("R1", int'(smp_ready), 1, "ready after reset");

    // R2 and R3, limit level 0
    tag = "R2"; lim_sel = 2'd0;
    send(1, -174, 47);
    chk("R2", int'(dcm_mode), 0, "after 47 low");
    send(1, -174, 1);
    chk("R2", int'(dcm_mode), 1, "after 48 low");

    // R9: low samples and +60 hold discontinuous mode
    tag = "R9";
    send(1, -300, 5);
    send(1, 0, 3);
    tag = "R5";
    send(1, 60, 1);
    chk("R5", int'(dcm_mode), 1, "exactly +60 keeps mode");
    send(1, 61, 1);
    chk("R5", int'(dcm_mode), 0, "+61 exits");
    tag = "R9";
    send(1, -174, 47);
    chk("R9", int'(dcm_mode), 0, "re-entry needs full run");
    send(1, -174, 1);
    chk("R9", int'(dcm_mode), 1, "re-entry after 48");
    leave_dcm();

    // R4: sample equal to threshold restarts the run
    tag = "R4";
    send(1, -174, 30);
    send(1, -173, 1);
    send(1, -174, 47);
    chk("R4", int'(dcm_mode), 0, "run restarted by at-threshold");
    send(1, -174, 1);
    chk("R4", int'(dcm_mode), 1, "full run after restart");
    leave_dcm();

    // R3: limit level 1 and 2/3
    tag = "R3"; lim_sel = 2'd1;
    send(1, -157, 48);
    chk("R3", int'(dcm_mode), 0, "sel1 at threshold no entry");
    send(1, -158, 48);
    chk("R3", int'(dcm_mode), 1, "sel1 below threshold entry");
    leave_dcm();
    lim_sel = 2'd2;
    send(1, -126, 48);
    chk("R3", int'(dcm_mode), 0, "sel2 at threshold no entry");
    send(1, -127, 48);
    chk("R3", int'(dcm_mode), 1, "sel2 entry");
    leave_dcm();
    lim_sel = 2'd3;
    send(1, -127, 48);
    chk("R3", int'(dcm_mode), 1, "sel3 entry");
    leave_dcm();
    lim_sel = 2'd0;
    send(1, -170, 48);
    chk("R3", int'(dcm_mode), 0, "sel0 ignores -170");

    // R10: idle cycles do not break the run
    tag = "R10";
    for (int k = 0; k < 47; k++) begin
      send(1, -200, 1);
      send(0, 500, 1);
    end
    chk("R10", int'(dcm_mode), 0, "47 low with gaps");
    send(1, -200, 1);
    chk("R10", int'(dcm_mode), 1, "48 low with gaps");

    // R8: offered code without valid is ignored
    tag = "R8";
    send(0, 1000, 4);
    chk("R8", int'(dcm_mode), 1, "no valid keeps mode");

    // R6: configuration disable
    tag = "R6";
    @(negedge clk); #1 dcm_en = 1'b0;
    expect_mode("R6", 0);
    #1 dcm_en = 1'b1;
    send(1, -200, 40);
    @(negedge clk); #1 dcm_en = 1'b0;
    @(negedge clk); #1 dcm_en = 1'b1;
    send(1, -200, 8);
    chk("R6", int'(dcm_mode), 0, "run cleared by config off");
    send(1, -200, 40);
    chk("R6", int'(dcm_mode), 1, "fresh run after config on");

    // R7: switching disable
    tag = "R7";
    @(negedge clk); #1 sw_en = 1'b0;
    expect_mode("R7", 0);
    #1 sw_en = 1'b1;
    send(1, -200, 40);
    @(negedge clk); #1 sw_en = 1'b0;
    @(negedge clk); #1 sw_en = 1'b1;
    send(1, -200, 8);
    chk("R7", int'(dcm_mode), 0, "run cleared by switching off");
    send(1, -200, 40);
    chk("R7", int'(dcm_mode), 1, "fresh run after switching on");

    // R1: reset during discontinuous mode
    tag = "R1";
    @(negedge clk); #1 rst_n = 1'b0;
    @(negedge clk);
    chk("R1", int'(dcm_mode), 0, "mode after mid-run reset");
    chk("R1", int'(smp_ready), 0, "ready after mid-run reset");
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule